// File: doc/BRIEF.md
# Port Unlock Sequence Detector

This block watches the write traffic on an I/O bus. It opens access to a bank of extended registers only after software has written a fixed 17-byte key, one byte at a time and in the right order, to the key port. The key port is any port address whose upper byte is 0xBC. The block drives one registered output, `unlocked`. Neighbouring logic uses this flag to gate reads and writes to the extended registers. Software normally writes the key with interrupts disabled, so the key bytes arrive one after another. Writes to other ports may still appear between key bytes, and the detector ignores them.

A key-port write that does not carry the expected byte counts as a wrong byte. A wrong byte throws away the progress made so far and clears the flag. If the wrong byte is itself the first key byte (0xFF), the search restarts one position in, because that byte has already begun a new attempt. Once the flag is set, it stays set through repeated correct key writes and through traffic on other ports. It falls when a wrong byte reaches the key port, or when reset is applied.

Top module: `port_unlock_detector`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `unlocked` reads 0 after that edge, and key progress returns to the start.
- R2: Seventeen key-port writes carrying FF,00,FF,77,B3,51,A8,D4,62,39,9C,46,2B,15,8A,CD,EE (hex), in that order, set `unlocked` to 1 at the clock edge that samples the seventeenth write (0xEE).
- R3: `unlocked` stays 0 while fewer than all 17 key bytes have been matched, including right after the sixteenth byte (0xCD).
- R4: A write with `io_wr`=1 whose address upper byte is not 0xBC changes neither the flag nor the key progress, even when it falls between two key bytes. This includes an address whose lower byte is 0xBC.
- R5: A cycle with `io_wr`=0 changes neither the flag nor the key progress, whatever the address and data are.
- R6: A key-port write whose data is not the expected key byte, and is not 0xFF, resets the progress to the start. A full key is then needed to unlock.
- R7: A wrong key-port byte equal to 0xFF restarts the progress at position one. The remaining 16 bytes (00 through EE) then unlock.
- R8: While `unlocked` is 1, a wrong key-port byte clears it at the clock edge that samples that write.
- R9: While `unlocked` is 1, key-port writes that match the expected sequence keep it at 1, and a further complete key leaves it at 1.
- R10: The lower byte of the address does not affect key matching. Any address 0xBC00 to 0xBCFF is the key port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one write per cycle while high |
| io_addr | input | 16 | I/O port address of the write |
| io_data | input | 8 | Data byte of the write |
| unlocked | output | 1 | High once the full key has been received; gates the extended registers |

## Verification
Every result of this block comes from one register stage. A write sampled at a rising edge shows its effect on `unlocked` right after that same edge, and the sixteenth-byte and seventeenth-byte outcomes are due one cycle apart. The bench drives each write on a falling edge and holds it for one full cycle. It reads `unlocked` on the next falling edge, half a cycle after the edge that took the write, and only then drives the next write. As a result, every check sees exactly the effect of the one write before it. Progress that the flag cannot show (after partial keys, reset, or a restart at position one) is observed by following it with a known tail of key bytes and checking the edge at which `unlocked` rises.

// File: rtl/unlock_pkg.sv
// Package: shared constants and the key table function for the port
// unlock detector. Assumes the key is a fixed, non-empty byte sequence.
package unlock_pkg;

    localparam int DATA_W  = 8;
    localparam int KEY_LEN = 17;
    localparam int IDX_W   = $clog2(KEY_LEN);

    // Returns the key byte expected at position pos (0 is first).
    function automatic logic [DATA_W-1:0] key_byte(input int unsigned pos);
        logic [DATA_W-1:0] b;
        case (pos)
            0:       b = 8'hFF;
            1:       b = 8'h00;
            2:       b = 8'hFF;
            3:       b = 8'h77;
            4:       b = 8'hB3;
            5:       b = 8'h51;
            6:       b = 8'hA8;
            7:       b = 8'hD4;
            8:       b = 8'h62;
            9:       b = 8'h39;
            10:      b = 8'h9C;
            11:      b = 8'h46;
            12:      b = 8'h2B;
            13:      b = 8'h15;
            14:      b = 8'h8A;
            15:      b = 8'hCD;
            16:      b = 8'hEE;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/unlock_port_decode.sv
// Module: address qualifier. Marks a write as a key-port write when the
// strobe is high and the masked address equals the key port pattern.
// Assumes a single-cycle write strobe per transfer; purely combinational.
module unlock_port_decode #(
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hFF00,
    parameter logic [ADDR_W-1:0] PORT_HIT  = 16'hBC00
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              key_wr
);

    // Qualify the write strobe with the masked address compare.
    always_comb begin
        key_wr = io_wr && ((io_addr & ADDR_MASK) == PORT_HIT);
    end

endmodule

// File: rtl/unlock_key_rom.sv
// Module: key lookup. Builds the key table from the package function and
// returns the byte expected at the current progress index, plus the first
// key byte used for resynchronisation. Assumes idx stays below KEY_LEN;
// out-of-range indices return zero.
module unlock_key_rom
    import unlock_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] exp_byte,
    output logic [DATA_W-1:0] first_byte
);

    logic [DATA_W-1:0] key_tab [KEY_LEN];

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign key_tab[g] = key_byte(g);
    end

    // Select the expected byte for the current position.
    always_comb begin
        if (idx < IDX_W'(KEY_LEN)) begin
            exp_byte = key_tab[idx];
        end else begin
            exp_byte = '0;
        end
        first_byte = key_tab[0];
    end

endmodule

// File: rtl/unlock_seq_tracker.sv
// Module: key progress state machine. Advances one position per matching
// key-port write, raises the unlocked flag on the last byte, and on a wrong
// byte clears the flag and restarts (at position one if the wrong byte is
// the first key byte). Assumes key_wr is high for one cycle per write.
module unlock_seq_tracker
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] io_data,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic [DATA_W-1:0] first_byte,
    output logic [IDX_W-1:0]  progress,
    output logic              unlocked
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);

    logic              hit;
    logic              at_last;
    logic              resync;
    logic [IDX_W-1:0]  next_idx;
    logic              next_unl;

    // Decide the next progress and flag for a key-port write.
    always_comb begin
        hit      = (io_data == exp_byte);
        at_last  = (progress == LAST_IDX);
        resync   = (io_data == first_byte);
        next_idx = progress;
        next_unl = unlocked;
        if (hit) begin
            if (at_last) begin
                next_idx = '0;
                next_unl = 1'b1;
            end else begin
                next_idx = progress + 1'b1;
            end
        end else begin
            next_unl = 1'b0;
            next_idx = resync ? IDX_W'(1) : '0;
        end
    end

    // Register progress and flag; only key-port writes update them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            progress <= '0;
            unlocked <= 1'b0;
        end else if (key_wr) begin
            progress <= next_idx;
            unlocked <= next_unl;
        end
    end

endmodule

// File: rtl/port_unlock_detector.sv
// Module: top of the port unlock detector. Watches I/O writes, compares
// key-port data against the fixed key and drives the unlocked flag.
// Assumes synchronous active-low reset and one write per strobe cycle.
module port_unlock_detector
    import unlock_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hFF00,
    parameter logic [ADDR_W-1:0] PORT_HIT  = 16'hBC00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    output logic              unlocked
);

    logic              key_wr;
    logic [IDX_W-1:0]  match_idx;
    logic [DATA_W-1:0] exp_byte;
    logic [DATA_W-1:0] first_byte;

    unlock_port_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_MASK(ADDR_MASK),
        .PORT_HIT (PORT_HIT)
    ) u_decode (
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .key_wr (key_wr)
    );

    unlock_key_rom u_rom (
        .idx       (match_idx),
        .exp_byte  (exp_byte),
        .first_byte(first_byte)
    );

    unlock_seq_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .io_data   (io_data),
        .exp_byte  (exp_byte),
        .first_byte(first_byte),
        .progress  (match_idx),
        .unlocked  (unlocked)
    );

endmodule

// File: rtl/port_unlock_detector_chk.sv
// Module: assertion checker for the port unlock detector, attached by bind.
// Observes the ports plus the progress index and expected key byte.
module port_unlock_detector_chk
    import unlock_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hFF00,
    parameter logic [ADDR_W-1:0] PORT_HIT  = 16'hBC00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_data,
    input logic              unlocked,
    input logic [IDX_W-1:0]  match_idx,
    input logic [DATA_W-1:0] exp_byte
);

    logic port_wr;
    assign port_wr = io_wr && ((io_addr & ADDR_MASK) == PORT_HIT);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!unlocked && match_idx == '0));

    // R4 R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> ($stable(unlocked) && $stable(match_idx)));

    // R2 R3
    rise_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(match_idx) == IDX_W'(KEY_LEN - 1)
                             && $past(io_data) == key_byte(KEY_LEN - 1)));

    // R8
    mismatch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && io_data != exp_byte) |=> !unlocked);

    // R6 R7
    mismatch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && io_data != exp_byte) |=>
            (match_idx == (($past(io_data) == key_byte(0)) ? IDX_W'(1) : IDX_W'(0))));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_idx < IDX_W'(KEY_LEN));

endmodule

bind port_unlock_detector port_unlock_detector_chk #(
    .ADDR_W   (ADDR_W),
    .ADDR_MASK(ADDR_MASK),
    .PORT_HIT (PORT_HIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_data  (io_data),
    .unlocked (unlocked),
    .match_idx(match_idx),
    .exp_byte (exp_byte)
);

// File: tb/port_unlock_detector_tb.sv
`timescale 1ns/1ps
// Bench: table-driven key walk followed by directed corner cases.
module port_unlock_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr;
    logic [15:0] io_addr;
    logic [7:0]  io_data;
    logic        unlocked;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    localparam logic [7:0] KEY [17] = '{8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3,
        8'h51, 8'hA8, 8'hD4, 8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15,
        8'h8A, 8'hCD, 8'hEE};

    // {wr, addr, data, expected unlocked after the edge}
    localparam logic [25:0] VEC [19] = '{
        {1'b1, 16'hBC00, 8'hFF, 1'b0},
        {1'b1, 16'hBC00, 8'h00, 1'b0},
        {1'b1, 16'hBC00, 8'hFF, 1'b0},
        {1'b1, 16'hBC00, 8'h77, 1'b0},
        {1'b1, 16'hBC00, 8'hB3, 1'b0},
        {1'b1, 16'h7F00, 8'h12, 1'b0},   // R4 foreign port between bytes
        {1'b1, 16'hBC00, 8'h51, 1'b0},
        {1'b1, 16'hBC00, 8'hA8, 1'b0},
        {1'b1, 16'hBC00, 8'hD4, 1'b0},
        {1'b1, 16'hBC00, 8'h62, 1'b0},
        {1'b0, 16'hBC00, 8'h55, 1'b0},   // R5 strobe low on key port
        {1'b1, 16'hBC00, 8'h39, 1'b0},
        {1'b1, 16'hBC00, 8'h9C, 1'b0},
        {1'b1, 16'hBC00, 8'h46, 1'b0},
        {1'b1, 16'hBC00, 8'h2B, 1'b0},
        {1'b1, 16'hBC00, 8'h15, 1'b0},
        {1'b1, 16'hBC00, 8'h8A, 1'b0},
        {1'b1, 16'hBC00, 8'hCD, 1'b0},   // R3 sixteen bytes, still locked
        {1'b1, 16'hBC00, 8'hEE, 1'b1}    // R2 seventeenth byte unlocks
    };

    port_unlock_detector u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_data (io_data),
        .unlocked(unlocked)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: unlocked=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, check at the next falling edge.
    task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d,
                       input logic exp, input string tag);
        io_wr   = wr;
        io_addr = a;
        io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
        check(tag, unlocked, exp);
    endtask

    // Write key bytes from position 'from' to the end on port {BC, lo}.
    task automatic key_run(input int from, input logic [7:0] lo,
                           input logic mid_exp, input logic end_exp, input string tag);
        for (int i = from; i < 17; i++) begin
            cyc(1'b1, {8'hBC, lo + 8'(i)}, KEY[i], (i == 16) ? end_exp : mid_exp, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: unlocked=%0b expected=finish", unlocked);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_data = '0;
        repeat (2) @(negedge clk);
        check("R1 reset state", unlocked, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < 19; v++) begin
            cyc(VEC[v][25], VEC[v][24:9], VEC[v][8:1], VEC[v][0], "R2 R3 R4 R5 table");
        end

        // R4: foreign ports, including lower byte BC, leave flag set
        cyc(1'b1, 16'h7FBC, 8'h00, 1'b1, "R4 foreign port keeps flag");
        cyc(1'b1, 16'h00BC, 8'h42, 1'b1, "R4 lower byte BC ignored");
        // R9 R10: repeated key on varying lower bytes keeps flag
        key_run(0, 8'h30, 1'b1, 1'b1, "R9 R10 repeat key");
        // R8: wrong byte clears
        cyc(1'b1, 16'hBC77, 8'h55, 1'b0, "R8 wrong byte clears");

        // R6: wrong non-FF byte mid-key discards progress
        for (int i = 0; i < 4; i++) cyc(1'b1, 16'hBC00, KEY[i], 1'b0, "R6 prefix");
        cyc(1'b1, 16'hBC00, 8'h12, 1'b0, "R6 wrong byte");
        key_run(4, 8'h00, 1'b0, 1'b0, "R6 tail after restart stays locked");
        key_run(0, 8'h00, 1'b0, 1'b1, "R6 full key after restart");

        // R7: FF as wrong byte restarts at position one
        cyc(1'b1, 16'hBC00, 8'h01, 1'b0, "R8 clear before R7");
        for (int i = 0; i < 5; i++) cyc(1'b1, 16'hBCFF, KEY[i], 1'b0, "R7 prefix");
        cyc(1'b1, 16'hBCFF, 8'hFF, 1'b0, "R7 FF mismatch");
        key_run(1, 8'h00, 1'b0, 1'b1, "R7 tail from position one unlocks");

        // R7: leading extra FF before full key
        cyc(1'b1, 16'hBC00, 8'h02, 1'b0, "R8 clear again");
        cyc(1'b1, 16'hBC00, 8'hFF, 1'b0, "R7 extra FF");
        key_run(0, 8'h00, 1'b0, 1'b1, "R7 extra FF then key");

        // R1: reset clears flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears flag", unlocked, 1'b0);
        rst_n = 1'b1;

        // R1 R3: sixteen bytes, reset, last byte must not unlock
        for (int i = 0; i < 16; i++) cyc(1'b1, 16'hBC00, KEY[i], 1'b0, "R3 sixteen bytes");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b1, 16'hBC00, KEY[16], 1'b0, "R1 progress cleared by reset");
        key_run(0, 8'h10, 1'b0, 1'b1, "R2 key after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule